// File: doc/BRIEF.md
# Illegal Instruction Exception Sequencer

This block sits next to a processor's decode stage. It recognises two faults at decode time. The first is an opcode with no defined meaning. The second is an instruction that sits in the slot right after a delayed branch and either is undefined or would rewrite the program counter. When a fault is seen, the block flushes the younger pipeline contents in the same cycle, so the faulting instruction never executes. It then takes over a single memory port to run the exception entry sequence.

The sequence has four steps. It saves the status word below the current stack pointer. It saves a return address below that. It reads a handler address from a vector table and reloads the program counter with it. The redirect is a plain jump, with no slot instruction after it. The return address depends on the fault. A slot fault pushes the branch destination of the delayed branch that came before the slot. An ordinary undefined opcode pushes the address of the offending instruction itself. Each fault has its own vector.

Top module: `illegal_exc_seq`

## Requirements
- R1: When `dec_valid` and `dec_undef` are high, `dec_in_slot` is low and `busy` is low, a general illegal-instruction exception starts. `flush` is high in that same cycle and only in that cycle.
- R2: When `dec_valid` and `dec_in_slot` are high, at least one of `dec_undef` or `dec_pc_write` is high, and `busy` is low, a slot exception starts. A PC-writing instruction outside a slot starts nothing. A slot instruction that is defined and does not write the PC starts nothing.
- R3: When no exception starts in a cycle, `flush` stays low and `busy` stays low after the next edge.
- R4: The first memory access is a write (`mem_we`=1) of the status word captured at detection, to address SP−4, where SP is the value captured at detection.
- R5: For a slot exception, the second access is a write of `slot_target` to SP−8.
- R6: For a general exception, the second access is a write of `dec_pc` to SP−8.
- R7: The third access is a read (`mem_we`=0) at `vbr` + 4×vector. The vector number is 4 for a general exception and 6 for a slot exception.
- R8: Each access holds `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until a cycle with `mem_ready` high completes it.
- R9: `sp_load` pulses in the cycle that completes the second write, with `sp_new` equal to SP−8.
- R10: One cycle after the read completes, `pc_load` is high for exactly one cycle. `pc_new` then equals the word read. In the next cycle there is no memory request and `busy` is low.
- R11: `busy` rises on the edge after detection and stays high through the `pc_load` cycle. While `busy` is high, the decode inputs start nothing and do not change the values being pushed.
- R12: After reset, `busy`, `flush`, `mem_req`, `pc_load` and `sp_load` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_undef | input | 1 | Decoded opcode is undefined |
| dec_pc_write | input | 1 | Decoded instruction would rewrite the PC |
| dec_in_slot | input | 1 | Decoded instruction sits in a delayed-branch slot |
| dec_pc | input | 32 | Address of the decoded instruction |
| slot_target | input | 32 | Destination of the preceding delayed branch |
| cur_sp | input | 32 | Current stack pointer |
| cur_sr | input | 32 | Current status word |
| vbr | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current access |
| flush | output | 1 | Discard younger pipeline contents |
| busy | output | 1 | Entry sequence in progress |
| pc_load | output | 1 | Load pc_new into the PC |
| pc_new | output | 32 | Handler address |
| sp_load | output | 1 | Load sp_new into the stack pointer |
| sp_new | output | 32 | Stack pointer after the two pushes |

## Verification
Suppose the captured fault kind is wrong. The second write then carries the other return address, and the read goes to the other vector, two or three accesses after detection. Suppose the captured context is stale or gets overwritten while `busy` is high. The push addresses or data then differ, starting with the first access on the edge after detection. A sequencer state that is wrong shows up in the access order, in a `pc_load` pulse that is missing or repeated, or in `busy` failing to drop. All of these are visible within a few cycles of the final ready. The sweep covers every combination of the four decode flags with zero to two wait states on each access.

// File: rtl/ill_exc_pkg.sv
package ill_exc_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [0:0] {
        EXC_GENERAL = 1'b0,
        EXC_SLOT    = 1'b1
    } exc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_SR,
        ST_SAVE_PC,
        ST_FETCH_VEC,
        ST_REDIRECT
    } seq_state_e;

    typedef struct packed {
        exc_kind_e         kind;
        logic [WORD_W-1:0] ret_pc;
        logic [WORD_W-1:0] sr;
        logic [WORD_W-1:0] sp;
    } exc_ctx_t;

    function automatic logic [WORD_W-1:0] vec_offset(exc_kind_e k,
                                                     int unsigned gen_vec,
                                                     int unsigned slot_vec);
        int unsigned n;
        n = (k == EXC_SLOT) ? slot_vec : gen_vec;
        return WORD_W'(n * (WORD_W / 8));
    endfunction

endpackage

// File: rtl/exc_detect.sv
module exc_detect
    import ill_exc_pkg::*;
(
    input  logic      dec_valid,
    input  logic      dec_undef,
    input  logic      dec_pc_write,
    input  logic      dec_in_slot,
    input  logic      armed,
    output logic      take,
    output exc_kind_e kind
);
    logic slot_fault;
    logic gen_fault;

    always_comb begin
        slot_fault = dec_in_slot && (dec_undef || dec_pc_write);
        gen_fault  = !dec_in_slot && dec_undef;
        take       = armed && dec_valid && (slot_fault || gen_fault);
        kind       = slot_fault ? EXC_SLOT : EXC_GENERAL;
    end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
    import ill_exc_pkg::*;
#(
    parameter int unsigned GEN_VEC  = 4,
    parameter int unsigned SLOT_VEC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  exc_kind_e         kind,
    input  logic [WORD_W-1:0] dec_pc,
    input  logic [WORD_W-1:0] slot_target,
    input  logic [WORD_W-1:0] cur_sr,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] vbr,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_new,
    output logic              sp_load,
    output logic [WORD_W-1:0] sp_new,
    output logic              busy
);
    localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

    seq_state_e        state_q;
    exc_ctx_t          ctx_q;
    logic [WORD_W-1:0] handler_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            ctx_q     <= '0;
            handler_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (take) begin
                    ctx_q.kind   <= kind;
                    ctx_q.ret_pc <= (kind == EXC_SLOT) ? slot_target : dec_pc;
                    ctx_q.sr     <= cur_sr;
                    ctx_q.sp     <= cur_sp;
                    state_q      <= ST_SAVE_SR;
                end
                ST_SAVE_SR:   if (mem_ready) state_q <= ST_SAVE_PC;
                ST_SAVE_PC:   if (mem_ready) state_q <= ST_FETCH_VEC;
                ST_FETCH_VEC: if (mem_ready) begin
                    handler_q <= mem_rdata;
                    state_q   <= ST_REDIRECT;
                end
                ST_REDIRECT:  state_q <= ST_IDLE;
                default:      state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_SAVE_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - STEP;
                mem_wdata = ctx_q.sr;
            end
            ST_SAVE_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ctx_q.sp - (STEP << 1);
                mem_wdata = ctx_q.ret_pc;
            end
            ST_FETCH_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vbr + vec_offset(ctx_q.kind, GEN_VEC, SLOT_VEC);
            end
            default: ;
        endcase
        sp_load = (state_q == ST_SAVE_PC) && mem_ready;
        sp_new  = ctx_q.sp - (STEP << 1);
        pc_load = (state_q == ST_REDIRECT);
        pc_new  = handler_q;
        busy    = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/illegal_exc_seq.sv
module illegal_exc_seq
    import ill_exc_pkg::*;
#(
    parameter int unsigned GEN_VEC  = 4,
    parameter int unsigned SLOT_VEC = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dec_valid,
    input  logic              dec_undef,
    input  logic              dec_pc_write,
    input  logic              dec_in_slot,
    input  logic [WORD_W-1:0] dec_pc,
    input  logic [WORD_W-1:0] slot_target,
    input  logic [WORD_W-1:0] cur_sp,
    input  logic [WORD_W-1:0] cur_sr,
    input  logic [WORD_W-1:0] vbr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              flush,
    output logic              busy,
    output logic              pc_load,
    output logic [WORD_W-1:0] pc_new,
    output logic              sp_load,
    output logic [WORD_W-1:0] sp_new
);
    logic      take;
    exc_kind_e kind;

    exc_detect u_detect (
        .dec_valid    (dec_valid),
        .dec_undef    (dec_undef),
        .dec_pc_write (dec_pc_write),
        .dec_in_slot  (dec_in_slot),
        .armed        (!busy),
        .take         (take),
        .kind         (kind)
    );

    exc_seq #(.GEN_VEC(GEN_VEC), .SLOT_VEC(SLOT_VEC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .take        (take),
        .kind        (kind),
        .dec_pc      (dec_pc),
        .slot_target (slot_target),
        .cur_sr      (cur_sr),
        .cur_sp      (cur_sp),
        .vbr         (vbr),
        .mem_ready   (mem_ready),
        .mem_rdata   (mem_rdata),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .pc_load     (pc_load),
        .pc_new      (pc_new),
        .sp_load     (sp_load),
        .sp_new      (sp_new),
        .busy        (busy)
    );

    assign flush = take;
endmodule

// File: rtl/illegal_exc_seq_sva.sv
module illegal_exc_seq_sva
    import ill_exc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              busy,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [WORD_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic              pc_load,
    input logic              sp_load
);
    // R8: an access that is not completed stays unchanged
    a_r8_access_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr)
                                  && $stable(mem_we) && $stable(mem_wdata));

    // R11: no new detection while the sequence runs
    a_r11_no_flush_busy: assert property (@(posedge clk) disable iff (rst)
        flush |-> !busy);

    // R1: detection leads to a busy sequence on the next edge
    a_r1_flush_starts: assert property (@(posedge clk) disable iff (rst)
        flush |=> busy && mem_req && mem_we);

    // R11: busy holds until the redirect
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (rst)
        busy && !pc_load |=> busy);

    // R10: single redirect pulse, then idle
    a_r10_single_redirect: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !pc_load && !busy && !mem_req);

    // R9: stack pointer update only on a completed write
    a_r9_sp_on_write: assert property (@(posedge clk) disable iff (rst)
        sp_load |-> mem_req && mem_we && mem_ready);

    // R12: no request outside the sequence
    a_r12_req_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);
endmodule

bind illegal_exc_seq illegal_exc_seq_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .pc_load   (pc_load),
    .sp_load   (sp_load)
);

// File: tb/tb_illegal_exc_seq.sv
module tb_illegal_exc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dec_valid = 0, dec_undef = 0, dec_pc_write = 0, dec_in_slot = 0;
    logic [31:0] dec_pc = 0, slot_target = 0, cur_sp = 0, cur_sr = 0, vbr = 0;
    logic        mem_req, mem_we, flush, busy, pc_load, sp_load;
    logic [31:0] mem_addr, mem_wdata, pc_new, sp_new;
    logic [31:0] mem_rdata = 0;
    logic        mem_ready = 0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    illegal_exc_seq dut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_undef(dec_undef),
        .dec_pc_write(dec_pc_write), .dec_in_slot(dec_in_slot), .dec_pc(dec_pc),
        .slot_target(slot_target), .cur_sp(cur_sp), .cur_sr(cur_sr), .vbr(vbr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .flush(flush), .busy(busy), .pc_load(pc_load), .pc_new(pc_new),
        .sp_load(sp_load), .sp_new(sp_new)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One memory access: check request, apply wait states, then complete it
    task automatic access(input logic we, input logic [31:0] addr,
                          input logic [31:0] data, input int waits,
                          input bit second_write, input logic [31:0] sp_exp,
                          input string req);
        for (int w = 0; w <= waits; w++) begin
            chk(mem_req === 1'b1, req, {31'b0, mem_req}, 32'h1);
            chk(mem_we === we, req, {31'b0, mem_we}, {31'b0, we});
            chk(mem_addr === addr, req, mem_addr, addr);
            if (we) chk(mem_wdata === data, req, mem_wdata, data);
            chk(busy === 1'b1, "R11 busy", {31'b0, busy}, 32'h1);
            if (w == waits) begin
                mem_ready = 1'b1;
                if (!we) mem_rdata = data;
                #1;
                if (second_write) begin
                    chk(sp_load === 1'b1, "R9 sp_load", {31'b0, sp_load}, 32'h1);
                    chk(sp_new === sp_exp, "R9 sp_new", sp_new, sp_exp);
                end
            end else begin
                #1;
                chk(sp_load === 1'b0, "R9 early sp_load", {31'b0, sp_load}, 32'h0);
            end
            @(posedge clk);
            @(negedge clk);
            mem_ready = 1'b0;
            mem_rdata = 32'h0;
        end
    endtask

    task automatic apply(input bit v, input bit u, input bit p, input bit s,
                         input int idx, input int waits, input bit hold);
        logic [31:0] pc, tgt, sp, sr, base, ret, vaddr, hnd;
        bit take, slot;
        pc   = 32'h0000_1000 + 32'(idx) * 32'h22;
        tgt  = 32'h0004_0000 + 32'(idx) * 32'h10;
        sp   = 32'h0000_8000 - 32'(idx) * 32'h40;
        sr   = 32'h0000_00F0 ^ 32'(idx);
        base = 32'h0001_0000 + 32'(idx % 4) * 32'h100;
        dec_valid = v; dec_undef = u; dec_pc_write = p; dec_in_slot = s;
        dec_pc = pc; slot_target = tgt; cur_sp = sp; cur_sr = sr; vbr = base;
        slot = s && (u || p);
        take = v && (slot || (!s && u));
        #1;
        chk(flush === take, slot ? "R2 flush" : (take ? "R1 flush" : "R3 flush"),
            {31'b0, flush}, {31'b0, take});
        @(posedge clk);
        @(negedge clk);
        if (!hold) begin
            dec_valid = 0; dec_undef = 0; dec_pc_write = 0; dec_in_slot = 0;
        end
        // disturb the inputs the sequence must have captured
        dec_pc = 32'hDEAD_0000; slot_target = 32'hBEEF_0000;
        cur_sp = 32'h1111_0000; cur_sr = 32'h2222_2222;
        if (!take) begin
            chk(busy === 1'b0, "R3 busy", {31'b0, busy}, 32'h0);
            chk(mem_req === 1'b0, "R3 req", {31'b0, mem_req}, 32'h0);
            return;
        end
        #1;
        if (hold) chk(flush === 1'b0, "R11 ignored", {31'b0, flush}, 32'h0);
        ret   = slot ? tgt : pc;
        vaddr = base + (slot ? 32'd24 : 32'd16);
        hnd   = 32'h0800_0000 + vaddr * 32'd3;
        access(1'b1, sp - 32'd4, sr, waits, 1'b0, 0, "R4 push status");
        access(1'b1, sp - 32'd8, ret, waits, 1'b1, sp - 32'd8,
               slot ? "R5 push slot target" : "R6 push insn address");
        access(1'b0, vaddr, hnd, waits, 1'b0, 0, "R7 vector read");
        if (hold) begin
            chk(flush === 1'b0, "R11 ignored", {31'b0, flush}, 32'h0);
            dec_valid = 0; dec_undef = 0; dec_pc_write = 0; dec_in_slot = 0;
        end
        chk(pc_load === 1'b1, "R10 pc_load", {31'b0, pc_load}, 32'h1);
        chk(pc_new === hnd, "R10 pc_new", pc_new, hnd);
        chk(mem_req === 1'b0, "R10 no req", {31'b0, mem_req}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk(pc_load === 1'b0, "R10 single", {31'b0, pc_load}, 32'h0);
        chk(busy === 1'b0, "R10 idle", {31'b0, busy}, 32'h0);
        chk(mem_req === 1'b0, "R10 idle req", {31'b0, mem_req}, 32'h0);
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 reset state
        chk(busy === 1'b0, "R12 busy", {31'b0, busy}, 32'h0);
        chk(flush === 1'b0, "R12 flush", {31'b0, flush}, 32'h0);
        chk(mem_req === 1'b0, "R12 req", {31'b0, mem_req}, 32'h0);
        chk(pc_load === 1'b0, "R12 pc_load", {31'b0, pc_load}, 32'h0);
        chk(sp_load === 1'b0, "R12 sp_load", {31'b0, sp_load}, 32'h0);
        @(negedge clk);
        for (int rep = 0; rep < 3; rep++) begin
            for (int c = 0; c < 16; c++) begin
                apply(c[3], c[2], c[1], c[0], rep * 16 + c, rep, 1'b0);
            end
        end
        // R11: decode inputs held asserted while busy
        apply(1'b1, 1'b1, 1'b0, 1'b0, 50, 1, 1'b1);
        apply(1'b1, 1'b0, 1'b1, 1'b1, 51, 2, 1'b1);
        apply(1'b1, 1'b1, 1'b1, 1'b1, 52, 0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule